// File: doc/BRIEF.md
# Two-wire register port

This block is a target-only serial port that is compatible with I2C. It gives a host controller write and read access to a small bank of control registers. The raw clock and data lines of the bus first pass through synchronizers clocked by a faster system clock. The block then looks for START, repeated START and STOP conditions and checks each byte bit by bit. The data line is open-drain, so the block never drives it high. It has only an output enable, and that enable pulls the line low.

A write transfer is made of four parts, in this order: the device byte, one register index, one data byte, and then STOP. The block turns the transfer into a single strobe that carries the index and the data. A read transfer first sends the register index in a short write phase. It follows with a repeated START and the device byte with its direction bit set. The block raises a one-cycle read request that carries the stored index, then shifts the byte it gets back onto the bus, most significant bit first. Each transfer moves exactly one data byte. The index does not step forward after a byte, and the block refuses any index at or above the size of the register bank.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset, sda_oe, wr_stb and rd_req are all 0.
- R2: The block acknowledges a device byte whose upper seven bits equal DEV_ADDR (default 7'h44) by holding sda_oe high through the ninth clock. Bit 0 of the device byte selects the direction: 0 means write and 1 means read. On any other device byte, the block releases the line on the ninth clock, and it acknowledges nothing and writes nothing until the next START.
- R3: The sequence START, device byte with bit 0 = 0, index, data, STOP acknowledges all three bytes. It produces exactly one wr_stb pulse, with wr_addr equal to the index and wr_data equal to the data byte.
- R4: The block refuses an index equal to or above REG_COUNT (default 12) by leaving the line released on its acknowledge clock. It then skips the data byte that follows, so no write happens.
- R5: The block leaves every byte after the first data byte of a transfer unacknowledged. It produces no further write for those bytes.
- R6: A repeated START followed by a device byte with bit 0 = 1 raises one rd_req pulse, with rd_addr equal to the last accepted index. The block then shifts rd_data onto the line MSB first. On the acknowledge clock of that byte and on every later clock of the transfer it releases the line, so any further byte reads 8'hFF.
- R7: A START or STOP that arrives in the middle of a byte cancels that byte. No write happens unless all eight data bits were received. A START always restarts the device-address match.
- R8: sda_oe changes only while the synchronized clock line is low.
- R9: wr_stb and rd_req are each single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Bus clock line as sensed at the pad |
| sda_i | input | 1 | Bus data line as sensed at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | When 1, pulls the data line low |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register index for the write |
| wr_data | output | 8 | Data byte for the write |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 8 | Register index for the read, held until the next accepted index |
| rd_data | input | 8 | Register contents; must be valid while rd_addr is stable after rd_req |

## Verification
The properties assume a bus controller that changes the data line only while the clock line is low, except when it deliberately makes a START or STOP. They also assume that it never starts or stops the bus while the block is pulling the data line low. The stimulus follows both rules. It splits every bus clock period into four quarters of eight system cycles each and moves data only in the first quarter of the low half. Because of that slow clock, every synchronized edge is seen well apart from the next one, and the register bank in the stimulus has many cycles to answer a read request before the first data bit goes out.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W   = 8;
  localparam int BITCNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_REG,
    PH_WDAT,
    PH_RDAT,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/twi_linemon.sv
module twi_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][1:0] chain_q;
  logic                        scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], {scl_i, sda_i}};
      scl_p   <= chain_q[LAST][1];
      sda_p   <= chain_q[LAST][0];
    end
  end

  always_comb begin
    scl_s     = chain_q[LAST][1];
    sda_s     = chain_q[LAST][0];
    scl_rise  = scl_s & ~scl_p;
    scl_fall  = ~scl_s & scl_p;
    start_det = scl_s & scl_p & sda_p & ~sda_s;
    stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  end
endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h44,
  parameter int         REG_COUNT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  output logic [BYTE_W-1:0] rd_addr
);
  localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);

  phase_e              ph_q, ph_d, nxt_q, nxt_d;
  logic [BITCNT_W-1:0] bit_q, bit_d;
  logic                ack_q, ack_d;
  logic [BYTE_W-1:0]   rx_q, rx_d, tx_q, tx_d, ptr_q, ptr_d, wd_q, wd_d;
  logic                oe_q, oe_d, wstb_d, rreq_d, wstb_q, rreq_q;
  logic                bus_ev;

  assign bus_ev = start_det | stop_det | scl_rise | scl_fall;

  always_comb begin
    ph_d   = ph_q;
    nxt_d  = nxt_q;
    bit_d  = bit_q;
    ack_d  = ack_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    ptr_d  = ptr_q;
    wd_d   = wd_q;
    oe_d   = oe_q;
    wstb_d = 1'b0;
    rreq_d = 1'b0;
    if (start_det) begin
      ph_d  = PH_DEV;
      bit_d = '0;
      ack_d = 1'b0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      ph_d  = PH_IDLE;
      bit_d = '0;
      ack_d = 1'b0;
      oe_d  = 1'b0;
    end else if (ph_q != PH_IDLE) begin
      if (scl_rise && !ack_q && bit_q < FULL) begin
        rx_d  = {rx_q[BYTE_W-2:0], sda_s};
        bit_d = bit_q + 1'b1;
      end else if (scl_fall && ack_q) begin
        ack_d = 1'b0;
        bit_d = '0;
        ph_d  = nxt_q;
        oe_d  = 1'b0;
        if (nxt_q == PH_RDAT) begin
          tx_d = rd_data;
          oe_d = ~rd_data[BYTE_W-1];
        end
      end else if (scl_fall && bit_q == FULL) begin
        ack_d = 1'b1;
        nxt_d = PH_SKIP;
        oe_d  = 1'b0;
        unique case (ph_q)
          PH_DEV: if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
            oe_d = 1'b1;
            if (rx_q[0]) begin
              nxt_d  = PH_RDAT;
              rreq_d = 1'b1;
            end else begin
              nxt_d = PH_REG;
            end
          end
          PH_REG: if (int'(rx_q) < REG_COUNT) begin
            oe_d  = 1'b1;
            ptr_d = rx_q;
            nxt_d = PH_WDAT;
          end
          PH_WDAT: begin
            oe_d   = 1'b1;
            wd_d   = rx_q;
            wstb_d = 1'b1;
          end
          default: ;
        endcase
      end else if (scl_fall && ph_q == PH_RDAT && bit_q != '0) begin
        tx_d = {tx_q[BYTE_W-2:0], 1'b0};
        oe_d = ~tx_q[BYTE_W-2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      nxt_q  <= PH_IDLE;
      bit_q  <= '0;
      ack_q  <= 1'b0;
      rx_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      wd_q   <= '0;
      oe_q   <= 1'b0;
      wstb_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      wstb_q <= wstb_d;
      rreq_q <= rreq_d;
      if (bus_ev) begin
        ph_q  <= ph_d;
        nxt_q <= nxt_d;
        bit_q <= bit_d;
        ack_q <= ack_d;
        rx_q  <= rx_d;
        tx_q  <= tx_d;
        ptr_q <= ptr_d;
        wd_q  <= wd_d;
        oe_q  <= oe_d;
      end
    end
  end

  assign sda_oe  = oe_q;
  assign wr_stb  = wstb_q;
  assign wr_addr = ptr_q;
  assign wr_data = wd_q;
  assign rd_req  = rreq_q;
  assign rd_addr = ptr_q;
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         REG_COUNT   = 12,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_req,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  twi_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_ctrl #(.DEV_ADDR(DEV_ADDR), .REG_COUNT(REG_COUNT)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr)
  );
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk #(
  parameter int REG_COUNT = 12
) (
  input logic       clk,
  input logic       rst_sn,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic [7:0] wr_addr,
  input logic       rd_req
);
  p_oe_moves_low_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_stb |=> !wr_stb);

  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_req |=> !rd_req);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !(wr_stb && rd_req));

  p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_stb |-> (int'(wr_addr) < REG_COUNT));
endmodule

bind twi_reg_slave twi_reg_slave_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .scl_s(scl_s), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .rd_req(rd_req)
);

// File: tb/twi_reg_slave_test.sv
module twi_reg_slave_test;
  localparam int Q = 8;

  typedef struct packed {
    logic       is_rd;
    logic [7:0] a;
    logic [7:0] d;
  } ev_t;

  logic clk, rst_n, scl, m_sda, sda_line;
  logic sda_oe, wr_stb, rd_req;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [7:0] regs [16];
  ev_t  expq [$];
  int   checks, errors, ev_seen, ev_exp;
  bit   done;

  assign sda_line = m_sda & ~sda_oe;
  assign rd_data  = (rd_addr < 8'd12) ? regs[rd_addr[3:0]] : 8'h00;

  twi_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) if (wr_stb) regs[wr_addr[3:0]] <= wr_data;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the design emits an event
  always @(negedge clk) begin
    if (rst_n && (wr_stb || rd_req)) begin
      ev_t got, want;
      ev_seen++;
      chk(!(wr_stb && rd_req), "R9 strobes exclusive", 1, 0);
      got.is_rd = rd_req;
      got.a     = rd_req ? rd_addr : wr_addr;
      got.d     = rd_req ? 8'h00 : wr_data;
      if (expq.size() == 0) begin
        chk(1'b0, "R5/R7 unexpected event", int'(got), 0);
      end else begin
        want = expq.pop_front();
        chk(got == want, "R3/R6 event match", int'(got), int'(want));
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q); scl = 1'b1; wt(2*Q); m_sda = 1'b0; wt(2*Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q); scl = 1'b1; wt(2*Q); m_sda = 1'b1; wt(2*Q);
  endtask

  task automatic bit_cycle(input logic b, output logic s);
    m_sda = b; wt(Q); scl = 1'b1; wt(Q); s = sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d, output logic ackline);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      d[i] = s;
    end
    bit_cycle(~mack, s);
    ackline = s;
  endtask

  task automatic push(input logic is_rd, input logic [7:0] a, input logic [7:0] d);
    ev_t e;
    e.is_rd = is_rd; e.a = a; e.d = d;
    expq.push_back(e);
    ev_exp++;
  endtask

  task automatic settle(input string tag);
    wt(4*Q);
    chk(expq.size() == 0 && ev_seen == ev_exp, tag, ev_seen, ev_exp);
  endtask

  initial begin
    logic ack, line;
    logic [7:0] d;
    checks = 0; errors = 0; ev_seen = 0; ev_exp = 0; done = 0;
    for (int i = 0; i < 16; i++) regs[i] = 8'h00;
    scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    wt(5);
    chk(sda_oe == 1'b0, "R1 sda_oe reset", sda_oe, 0);
    chk(wr_stb == 1'b0, "R1 wr_stb reset", wr_stb, 0);
    chk(rd_req == 1'b0, "R1 rd_req reset", rd_req, 0);
    rst_n = 1'b1;
    wt(10);

    // R3: plain write to index 3
    push(1'b0, 8'd3, 8'h5A);
    bus_start();
    send_byte(8'h88, ack); chk(ack, "R2 device ack", ack, 1);
    send_byte(8'd3, ack);  chk(ack, "R3 index ack", ack, 1);
    send_byte(8'h5A, ack); chk(ack, "R3 data ack", ack, 1);
    bus_stop();
    settle("R3 one write");

    // R3/R4: highest legal index
    push(1'b0, 8'd11, 8'hC3);
    bus_start();
    send_byte(8'h88, ack); chk(ack, "R2 device ack", ack, 1);
    send_byte(8'd11, ack); chk(ack, "R4 top index ack", ack, 1);
    send_byte(8'hC3, ack); chk(ack, "R3 data ack", ack, 1);
    bus_stop();
    settle("R3 top index write");

    // R4: first missing index
    bus_start();
    send_byte(8'h88, ack); chk(ack, "R2 device ack", ack, 1);
    send_byte(8'd12, ack); chk(!ack, "R4 index refused", ack, 0);
    send_byte(8'h99, ack); chk(!ack, "R4 data skipped", ack, 0);
    bus_stop();
    settle("R4 no write");

    // R2: other device address
    bus_start();
    send_byte(8'h8A, ack); chk(!ack, "R2 mismatch nack", ack, 0);
    send_byte(8'd2, ack);  chk(!ack, "R2 ignored index", ack, 0);
    send_byte(8'h44, ack); chk(!ack, "R2 ignored data", ack, 0);
    bus_stop();
    settle("R2 no write on mismatch");

    // R5: second data byte
    push(1'b0, 8'd5, 8'h11);
    bus_start();
    send_byte(8'h88, ack); chk(ack, "R2 device ack", ack, 1);
    send_byte(8'd5, ack);  chk(ack, "R3 index ack", ack, 1);
    send_byte(8'h11, ack); chk(ack, "R3 data ack", ack, 1);
    send_byte(8'h22, ack); chk(!ack, "R5 extra byte nack", ack, 0);
    bus_stop();
    settle("R5 single write");

    // R6: read index 3 with master nack
    push(1'b1, 8'd3, 8'h00);
    bus_start();
    send_byte(8'h88, ack); chk(ack, "R2 device ack", ack, 1);
    send_byte(8'd3, ack);  chk(ack, "R6 index ack", ack, 1);
    bus_start();
    send_byte(8'h89, ack); chk(ack, "R6 read device ack", ack, 1);
    recv_byte(1'b0, d, line);
    chk(d == 8'h5A, "R6 read data", d, 8'h5A);
    chk(line == 1'b1, "R6 released on ack", line, 1);
    bus_stop();
    settle("R6 one read request");

    // R6: read index 11, master acks, next byte is released
    push(1'b1, 8'd11, 8'h00);
    bus_start();
    send_byte(8'h88, ack); chk(ack, "R2 device ack", ack, 1);
    send_byte(8'd11, ack); chk(ack, "R6 index ack", ack, 1);
    bus_start();
    send_byte(8'h89, ack); chk(ack, "R6 read device ack", ack, 1);
    recv_byte(1'b1, d, line);
    chk(d == 8'hC3, "R6 read data", d, 8'hC3);
    recv_byte(1'b0, d, line);
    chk(d == 8'hFF, "R6 no further data", d, 8'hFF);
    bus_stop();
    settle("R6 read request count");

    // R7: STOP in the middle of a data byte
    bus_start();
    send_byte(8'h88, ack); chk(ack, "R2 device ack", ack, 1);
    send_byte(8'd4, ack);  chk(ack, "R7 index ack", ack, 1);
    for (int i = 0; i < 4; i++) bit_cycle(1'b1, line);
    bus_stop();
    settle("R7 partial byte not written");

    // R7: repeated START in the middle of the device byte
    push(1'b0, 8'd6, 8'h77);
    bus_start();
    bit_cycle(1'b1, line); bit_cycle(1'b0, line);
    bus_start();
    send_byte(8'h88, ack); chk(ack, "R7 restart device ack", ack, 1);
    send_byte(8'd6, ack);  chk(ack, "R7 index ack", ack, 1);
    send_byte(8'h77, ack); chk(ack, "R7 data ack", ack, 1);
    bus_stop();
    settle("R7 restart write");
    chk(sda_oe == 1'b0, "R8 line released at idle", sda_oe, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule